// File: doc/BRIEF.md
# Four-lane look-ahead first-order recursive filter

This block evaluates the first-order recursion y[n] = a·y[n−1] + x[n] on four consecutive samples in every clock cycle, so the logic runs at a quarter of the sample rate. One input word carries four 16-bit signed samples, and one output word carries the four matching filtered samples. The recursion is unrolled four times by look-ahead. Only the result of the last lane is kept as state. The loop that closes over that state has a single multiply-add by a⁴. Everything that depends only on the current inputs is computed one register stage earlier.

The caller supplies the coefficient and its second, third and fourth powers as Q1.16 values on four ports, and may change them at run time. Products are kept at full width. Each output lane is rounded to the nearest integer and clipped to the 16-bit range. The stored state keeps 16 fraction bits and is never clipped. A blank cycle (valid low) leaves both the state and the outputs untouched. Output words appear two cycles after the matching input word.

Top module: `iir1_lookahead4`

## Requirements
- R1: Driving rst_n low clears the state, out_vld and y_out to zero at once. The first valid word after reset is filtered from a zero state.
- R2: Lane j of x_in is bits [16j+15:16j] and holds sample 4k+j, so lane 0 is the oldest sample. y_out uses the same packing. With all coefficients zero, each output lane equals its input lane.
- R3: When coef_a1..coef_a4 carry a, a², a³ and a⁴ exactly in Q1.16, every output lane equals the sample-by-sample recursion. In that recursion the state carried from one word to the next is the unclipped lane-3 sum, rounded half-up to 16 fraction bits.
- R4: Each output lane is rounded to the nearest integer, with exact halves going toward positive infinity. For example, 0.5 gives 1 and −0.5 gives 0.
- R5: An output lane above 32767 reads 32767, and one below −32768 reads −32768. The state keeps the unclipped value, so later lanes follow the true recursion.
- R6: out_vld equals in_vld delayed by two clock cycles. y_out changes only in a cycle in which out_vld rises or stays high.
- R7: While in_vld is low, the input samples are ignored, the state does not change and y_out holds its last value. The next valid word continues the recursion as if the blank cycles had not occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at one quarter of the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input word valid |
| x_in | input | 64 | Four signed 16-bit samples, lane 0 in the low bits |
| coef_a1 | input | 18 | Coefficient a, signed Q1.16 |
| coef_a2 | input | 18 | a², signed Q1.16 |
| coef_a3 | input | 18 | a³, signed Q1.16 |
| coef_a4 | input | 18 | a⁴, signed Q1.16 |
| out_vld | output | 1 | Output word valid |
| y_out | output | 64 | Four signed 16-bit filtered samples, lane 0 in the low bits |

## Verification
The coefficient is swept over every value m/16 with |m| ≤ 15. Under each value, random full-range samples are driven with random blank cycles. Negative values test the sign handling of the odd powers, and the zero coefficient separates the lanes so that any swap or shift shows up. A single unit impulse with a = 0.5 lands exactly on the ±0.5 rounding ties. Long runs of the largest positive and negative samples with a = 15/16 drive the outputs well into clipping. Each case is compared against a serial recursion kept in exact integer arithmetic, so a state that was clipped, rounded the wrong way, or disturbed during a blank cycle shows up as a lane mismatch.

// File: rtl/iir4_pkg.sv
package iir4_pkg;
  // Look-ahead factor: samples handled per clock, fixed by the lane equations.
  localparam int unsigned LANES = 4;
endpackage

// File: rtl/iir_round_sat.sv
// Round half-up by SH bits, then clip (SAT=1) or wrap (SAT=0) to OW bits.
// The range flags are produced in both variants.
module iir_round_sat #(
  parameter int unsigned AW  = 60,
  parameter int unsigned SH  = 32,
  parameter int unsigned OW  = 16,
  parameter bit          SAT = 1'b1
) (
  input  logic signed [AW-1:0] acc,
  output logic signed [OW-1:0] res,
  output logic                 ovf_hi,
  output logic                 ovf_lo
);
  localparam logic signed [AW-1:0] HALF = {{(AW-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
  localparam logic signed [AW-1:0] MAXW = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINW = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [AW-1:0] shifted;

  always_comb begin
    shifted = (acc + HALF) >>> SH;
    ovf_hi  = shifted > MAXW;
    ovf_lo  = shifted < MINW;
  end

  generate
    if (SAT) begin : g_clip
      always_comb begin
        if (ovf_hi)      res = MAXW[OW-1:0];
        else if (ovf_lo) res = MINW[OW-1:0];
        else             res = shifted[OW-1:0];
      end
    end else begin : g_wrap
      always_comb res = shifted[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/iir_ffwd_stage.sv
// Feed-forward register stage. Lane j holds the sum over i<=j of a^(j-i)*x_i,
// in units of 2^-FW. It depends on the current word only.
module iir_ffwd_stage
  import iir4_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned CW  = 18,
  parameter int unsigned FW  = 16,
  parameter int unsigned FSW = DW + CW + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic [LANES*DW-1:0]      x_in,
  input  logic [(LANES-1)*CW-1:0]  coef_lo,
  output logic                     ff_vld,
  output logic [LANES*FSW-1:0]     ff_sum
);
  logic signed [FSW-1:0] xs [LANES];
  logic signed [FSW-1:0] cs [LANES-1];
  logic signed [FSW-1:0] acc;
  logic [LANES*FSW-1:0]  sum_d;
  logic [LANES*FSW-1:0]  sum_q;
  logic                  vld_q;

  always_comb begin
    for (int i = 0; i < LANES; i++)
      xs[i] = {{(FSW-DW){x_in[i*DW+DW-1]}}, x_in[i*DW +: DW]};
    for (int k = 0; k < LANES-1; k++)
      cs[k] = {{(FSW-CW){coef_lo[k*CW+CW-1]}}, coef_lo[k*CW +: CW]};
    sum_d = '0;
    acc   = '0;
    for (int j = 0; j < LANES; j++) begin
      acc = {{(FSW-DW-FW){x_in[j*DW+DW-1]}}, x_in[j*DW +: DW], {FW{1'b0}}};
      for (int i = 0; i < j; i++)
        acc = acc + cs[j-i-1] * xs[i];
      sum_d[j*FSW +: FSW] = acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) sum_q <= sum_d;
    end
  end

  assign ff_vld = vld_q;
  assign ff_sum = sum_q;
endmodule

// File: rtl/iir_state_loop.sv
// Feedback stage. The state is the lane-3 sum with FW fraction bits.
// Lane j output = a^(j+1)*s + feed-forward lane j. The state update is
// the only loop: one multiply by a^4 and one add.
module iir_state_loop
  import iir4_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned CW  = 18,
  parameter int unsigned FW  = 16,
  parameter int unsigned SW  = 40,
  parameter int unsigned FSW = DW + CW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ff_vld,
  input  logic [LANES*FSW-1:0] ff_sum,
  input  logic [LANES*CW-1:0]  coef,
  output logic                 out_vld,
  output logic [LANES*DW-1:0]  y_out
);
  localparam int unsigned AW = CW + SW + 2;
  localparam logic signed [DW-1:0] YMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] YMIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [SW-1:0] state_q, state_d;
  logic [LANES*DW-1:0]  y_q, y_d;
  logic                 vld_q;
  logic [LANES-1:0]     lane_hi, lane_lo;
  logic                 st_hi, st_lo;
  logic signed [AW-1:0] se;

  assign se = {{(AW-SW){state_q[SW-1]}}, state_q};

  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic signed [AW-1:0] ce, fe, acc;
      logic signed [DW-1:0] yl;
      assign ce  = {{(AW-CW){coef[j*CW+CW-1]}}, coef[j*CW +: CW]};
      assign fe  = {{(AW-FSW-FW){ff_sum[j*FSW+FSW-1]}}, ff_sum[j*FSW +: FSW], {FW{1'b0}}};
      assign acc = ce * se + fe;

      iir_round_sat #(.AW(AW), .SH(2*FW), .OW(DW), .SAT(1'b1)) u_out (
        .acc(acc), .res(yl), .ovf_hi(lane_hi[j]), .ovf_lo(lane_lo[j])
      );
      assign y_d[j*DW +: DW] = yl;

      if (j == LANES-1) begin : g_state
        iir_round_sat #(.AW(AW), .SH(FW), .OW(SW), .SAT(1'b0)) u_st (
          .acc(acc), .res(state_d), .ovf_hi(st_hi), .ovf_lo(st_lo)
        );
      end

      // R5: clipping lands on the range limits one cycle later
      p_clip_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_vld && lane_hi[j]) |=> ($signed(y_out[j*DW +: DW]) == YMAX));
      p_clip_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_vld && lane_lo[j]) |=> ($signed(y_out[j*DW +: DW]) == YMIN));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      y_q     <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= ff_vld;
      if (ff_vld) begin
        state_q <= state_d;
        y_q     <= y_d;
      end
    end
  end

  assign out_vld = vld_q;
  assign y_out   = y_q;

  // R7: a blank slot leaves state and outputs as they were
  p_state_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ff_vld |=> $stable(state_q));
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ff_vld |=> $stable(y_q));
  // R5: the unclipped state stays inside its register
  p_state_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ff_vld |-> !(st_hi || st_lo));
  // R1: leaving reset starts from a zero state
  p_reset_zero_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (state_q == '0 && !vld_q));
endmodule

// File: rtl/iir1_lookahead4.sv
module iir1_lookahead4
  import iir4_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 18,
  parameter int unsigned FW = 16,
  parameter int unsigned GW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [4*DW-1:0]     x_in,
  input  logic [CW-1:0]       coef_a1,
  input  logic [CW-1:0]       coef_a2,
  input  logic [CW-1:0]       coef_a3,
  input  logic [CW-1:0]       coef_a4,
  output logic                out_vld,
  output logic [4*DW-1:0]     y_out
);
  localparam int unsigned SW  = DW + GW + FW;
  localparam int unsigned FSW = DW + CW + 3;

  logic [LANES*CW-1:0]  coef_bus;
  logic                 ff_vld;
  logic [LANES*FSW-1:0] ff_sum;

  assign coef_bus = {coef_a4, coef_a3, coef_a2, coef_a1};

  iir_ffwd_stage #(.DW(DW), .CW(CW), .FW(FW), .FSW(FSW)) u_ffwd (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_in(x_in),
    .coef_lo(coef_bus[(LANES-1)*CW-1:0]),
    .ff_vld(ff_vld), .ff_sum(ff_sum)
  );

  iir_state_loop #(.DW(DW), .CW(CW), .FW(FW), .SW(SW), .FSW(FSW)) u_loop (
    .clk(clk), .rst_n(rst_n), .ff_vld(ff_vld), .ff_sum(ff_sum),
    .coef(coef_bus), .out_vld(out_vld), .y_out(y_out)
  );

  // R6: an output word always traces back to an input word two cycles earlier
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld, 2));
endmodule

// File: tb/tb_iir1_lookahead4.sv
module tb_iir1_lookahead4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [63:0] x_in = '0;
  logic [17:0] coef_a1 = '0, coef_a2 = '0, coef_a3 = '0, coef_a4 = '0;
  logic        out_vld;
  logic [63:0] y_out;

  iir1_lookahead4 dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_in(x_in),
    .coef_a1(coef_a1), .coef_a2(coef_a2), .coef_a3(coef_a3), .coef_a4(coef_a4),
    .out_vld(out_vld), .y_out(y_out)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    m_cur  = 0;
  longint st_v  = 0;       // model state, units of 2^-32
  bit    pe1_v, pe2_v;
  int    pe1_y [4];
  int    pe2_y [4];
  int    last_y [4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int lane(input int j);
    return int'($signed(y_out[j*16 +: 16]));
  endfunction

  task automatic set_a(input int m);
    m_cur   = m;
    coef_a1 = 18'(m * 4096);
    coef_a2 = 18'(m * m * 256);
    coef_a3 = 18'(m * m * m * 16);
    coef_a4 = 18'(m * m * m * m);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    in_vld = 1'b0;
    x_in   = '0;
    @(negedge clk);
    @(negedge clk);
    chk(out_vld == 1'b0, "R1", "out_vld in reset", longint'(out_vld), 0);
    for (int j = 0; j < 4; j++)
      chk(lane(j) == 0, "R1", $sformatf("lane %0d in reset", j), lane(j), 0);
    rst_n = 1'b1;
    st_v  = 0;
    pe1_v = 1'b0;
    pe2_v = 1'b0;
    for (int j = 0; j < 4; j++) begin
      pe1_y[j] = 0; pe2_y[j] = 0; last_y[j] = 0;
    end
  endtask

  // One clock: check the word expected two cycles after its drive, then drive the next
  task automatic step(input bit vld, input int x0, input int x1, input int x2,
                      input int x3, input string tag);
    int     xs [4];
    longint v;
    longint s16;
    xs[0] = x0; xs[1] = x1; xs[2] = x2; xs[3] = x3;
    @(negedge clk);
    chk(out_vld == pe2_v, "R6", "out_vld", longint'(out_vld), longint'(pe2_v));
    for (int j = 0; j < 4; j++)
      chk(lane(j) == pe2_y[j], pe2_v ? tag : "R7",
          $sformatf("lane %0d (a=%0d/16)", j, m_cur), lane(j), pe2_y[j]);
    pe2_v = pe1_v;
    pe2_y = pe1_y;
    pe1_v = vld;
    if (vld) begin
      v = st_v;
      for (int j = 0; j < 4; j++) begin
        v = (longint'(m_cur) * v) >>> 4;
        v = v + (longint'(xs[j]) <<< 32);
        last_y[j] = sat16((v + (longint'(1) <<< 31)) >>> 32);
      end
      s16  = (v + 32768) >>> 16;
      st_v = s16 <<< 16;
    end
    pe1_y  = last_y;
    in_vld = vld;
    x_in   = {16'(xs[3]), 16'(xs[2]), 16'(xs[1]), 16'(xs[0])};
  endtask

  task automatic idle2();
    step(1'b0, 0, 0, 0, 0, "R7");
    step(1'b0, 0, 0, 0, 0, "R7");
  endtask

  task automatic run_all();
    do_reset();
    // R2: zero coefficient passes each lane through in place
    set_a(0);
    step(1'b1, 11, -22, 33, -44, "R2");
    idle2();
    chk(lane(0) == 11 && lane(1) == -22 && lane(2) == 33 && lane(3) == -44,
        "R2", "lane order", lane(1), -22);

    // R4: ties at +0.5 round up, at -0.5 round to zero
    do_reset();
    set_a(8);
    step(1'b1, 1, 0, 0, 0, "R4");
    idle2();
    chk(lane(0) == 1 && lane(1) == 1 && lane(2) == 0 && lane(3) == 0,
        "R4", "positive tie lane1", lane(1), 1);
    do_reset();
    set_a(8);
    step(1'b1, -1, 0, 0, 0, "R4");
    idle2();
    chk(lane(0) == -1 && lane(1) == 0 && lane(2) == 0 && lane(3) == 0,
        "R4", "negative tie lane1", lane(1), 0);

    // R5: drive into both clipping limits with a = 15/16
    do_reset();
    set_a(15);
    for (int b = 0; b < 12; b++) step(1'b1, 32767, 32767, 32767, 32767, "R5");
    idle2();
    for (int j = 0; j < 4; j++)
      chk(lane(j) == 32767, "R5", $sformatf("upper clip lane %0d", j), lane(j), 32767);
    for (int b = 0; b < 12; b++) step(1'b1, -32768, -32768, -32768, -32768, "R5");
    idle2();
    for (int j = 0; j < 4; j++)
      chk(lane(j) == -32768, "R5", $sformatf("lower clip lane %0d", j), lane(j), -32768);
    step(1'b1, 0, 0, 0, 0, "R5");
    step(1'b1, 30000, 0, -30000, 0, "R5");
    idle2();

    // R3 and R7: sweep every coefficient m/16, random data and blank slots
    for (int m = -15; m <= 15; m++) begin
      do_reset();
      set_a(m);
      for (int c = 0; c < 30; c++)
        step(($urandom % 5) != 0,
             int'($signed(16'($urandom))), int'($signed(16'($urandom))),
             int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R3");
      idle2();
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule